// File: doc/BRIEF.md
# Spare-Shift Unit Select Steering

This block steers unit-select lines inside one memory bank so that up to two faulty units are bypassed without any address comparison. The bank holds `Q` normal units and two spare units. One spare sits above the first normal unit and one sits below the last. Physical positions are numbered 0 to `Q+1`: position 0 is the upper spare, positions 1 to `Q` are the normal units, and position `Q+1` is the lower spare. A one-hot logical select picks a normal unit. Each physical position has a small switch. An active switch moves its select one place, either toward the upper spare or toward the lower spare.

Two control fields decide which switches are active. The upward field marks a run of positions starting at the top of the column. The downward field marks a run that ends at the bottom. Every select in a run shifts by one position toward its spare, so the marked faulty unit drops out of use. The output depends only on the present inputs, with no clock and no register, so the added path is a decode plus a two-level switch. A parameter reuses the same structure one level up, to steer bank selects. In that mode there is one field and a single spare at the far end.

Top module: `spare_shift_steer`

## Requirements
- R1: With both fields at zero in unit mode, logical select `i` enables physical position `i+1`, and neither spare is enabled.
- R2: In unit mode, an upward field value `a` other than zero moves every logical select whose home position `p = i+1` satisfies `p <= a` to position `p-1`. Position `a` is then never enabled. With `a = 1`, logical select 0 enables position 0.
- R3: In unit mode, a downward field value `b` other than zero moves every logical select whose home position satisfies `p >= b+1` to position `p+1`, unless R5 applies. When `b >= a`, position `b+1` is never enabled. With `b = 2`, logical select 2 enables position 4.
- R4: Two faults at positions `f1 < f2` are both bypassed by setting the upward field to `f1` and the downward field to `f2-1`. Neither faulty position is then enabled, for any single select.
- R5: When a home position lies in both runs, the upward move wins. With `a = 5` and `b = 2`, logical select 3 enables position 3.
- R6: The upper spare (position 0) is enabled only when the upward field is not zero and logical select 0 is asserted. The lower spare (last position) is enabled only when the downward field is not zero.
- R7: The number of asserted enables always equals the number of asserted logical selects. An all-zero select gives all-zero enables.
- R8: With `SINGLE = 1` the block has `Q+1` positions. Logical select `i` has home position `i`, and the spare is at position `Q`. The upward field has no effect. A downward value `b` other than zero moves every select with `i >= b-1` up by one, so position `b-1` is never enabled.
- R9: The enables follow a change of inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | Q | Logical unit selects, normally one-hot |
| fld_top_i | input | FW (clog2 of Q, or of Q+1 when SINGLE) | Upward run control field; zero means idle |
| fld_bot_i | input | FW | Downward run control field; zero means idle |
| en_o | output | Q+2 (Q+1 when SINGLE) | Physical position enables |

## Verification
The hardest case to reach is two runs that overlap, where the upward field exceeds the downward field. Here the priority between the two move directions decides the result. Ordinary repair settings never produce this case. The stimulus therefore sweeps every pair of field values, including the out-of-range and overlapping codes, against every single select. It also applies dense multi-hot selects under overlapping fields, to show that two selects never land on the same position.

// File: rtl/spare_shift_pkg.sv
package spare_shift_pkg;

    // Direction a single select takes through its switch.
    typedef enum logic [1:0] {
        ROUTE_IDLE = 2'd0,
        ROUTE_SELF = 2'd1,
        ROUTE_UP   = 2'd2,
        ROUTE_DOWN = 2'd3
    } route_e;

    // Width of a control field: enough codes to name every repairable position.
    function automatic int field_w(input int q, input bit single);
        int n;
        n = single ? q + 1 : q;
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Number of physical positions, spares included.
    function automatic int phys_n(input int q, input bit single);
        return single ? q + 1 : q + 2;
    endfunction

endpackage

// File: rtl/sss_act_decode.sv
// Thermometer decode of one control field into per-position switch activations.
module sss_act_decode #(
    parameter int  FW         = 3,
    parameter int  NP         = 10,
    parameter bit  TOWARD_TOP = 1'b1,
    parameter int  OFS        = 1
) (
    input  logic [FW-1:0] code_i,
    output logic [NP-1:0] act_o
);

    logic live;
    assign live = (code_i != '0);

    for (genvar k = 0; k < NP; k++) begin : g_pos
        if (TOWARD_TOP) begin : g_up
            // positions 0..code shift upward
            assign act_o[k] = live && (int'(code_i) >= k);
        end else if (k - OFS < 0) begin : g_never
            assign act_o[k] = 1'b0;
        end else begin : g_down
            // positions code+OFS..end shift downward
            assign act_o[k] = live && (int'(code_i) <= k - OFS);
        end
    end

endmodule

// File: rtl/sss_switch_cell.sv
// Per-position switch: forwards its own select to itself or one neighbour.
module sss_switch_cell
    import spare_shift_pkg::*;
(
    input  logic own_sel_i,
    input  logic act_top_i,
    input  logic act_bot_i,
    output logic to_self_o,
    output logic to_up_o,
    output logic to_down_o
);

    route_e route;

    always_comb begin
        if (!own_sel_i)     route = ROUTE_IDLE;
        else if (act_top_i) route = ROUTE_UP;
        else if (act_bot_i) route = ROUTE_DOWN;
        else                route = ROUTE_SELF;
    end

    always_comb begin
        to_self_o = 1'b0;
        to_up_o   = 1'b0;
        to_down_o = 1'b0;
        unique case (route)
            ROUTE_SELF: to_self_o = 1'b1;
            ROUTE_UP:   to_up_o   = 1'b1;
            ROUTE_DOWN: to_down_o = 1'b1;
            ROUTE_IDLE: ;
        endcase
    end

endmodule

// File: rtl/spare_shift_steer.sv
module spare_shift_steer
    import spare_shift_pkg::*;
#(
    parameter int Q      = 8,
    parameter bit SINGLE = 1'b0
) (
    input  logic [Q-1:0]                     sel_i,
    input  logic [field_w(Q, SINGLE)-1:0]    fld_top_i,
    input  logic [field_w(Q, SINGLE)-1:0]    fld_bot_i,
    output logic [phys_n(Q, SINGLE)-1:0]     en_o
);

    localparam int FW      = field_w(Q, SINGLE);
    localparam int NP      = phys_n(Q, SINGLE);
    localparam int HOME    = SINGLE ? 0 : 1;
    localparam int BOT_OFS = SINGLE ? -1 : 1;

    logic [NP-1:0] act_top_raw;
    logic [NP-1:0] act_top;
    logic [NP-1:0] act_bot;
    logic [NP-1:0] own_sel;
    logic [NP-1:0] to_self;
    logic [NP-1:0] to_up;
    logic [NP-1:0] to_down;

    sss_act_decode #(
        .FW(FW), .NP(NP), .TOWARD_TOP(1'b1), .OFS(0)
    ) top_dec_i (
        .code_i (fld_top_i),
        .act_o  (act_top_raw)
    );

    sss_act_decode #(
        .FW(FW), .NP(NP), .TOWARD_TOP(1'b0), .OFS(BOT_OFS)
    ) bot_dec_i (
        .code_i (fld_bot_i),
        .act_o  (act_bot)
    );

    // Single-field mode has no upper spare: the upward path is held idle.
    assign act_top = SINGLE ? '0 : act_top_raw;

    for (genvar j = 0; j < NP; j++) begin : g_cell
        if (j >= HOME && j < HOME + Q) begin : g_normal
            assign own_sel[j] = sel_i[j-HOME];
        end else begin : g_spare
            assign own_sel[j] = 1'b0;
        end

        sss_switch_cell cell_i (
            .own_sel_i (own_sel[j]),
            .act_top_i (act_top[j]),
            .act_bot_i (act_bot[j]),
            .to_self_o (to_self[j]),
            .to_up_o   (to_up[j]),
            .to_down_o (to_down[j])
        );
    end

    for (genvar j = 0; j < NP; j++) begin : g_merge
        logic from_below;
        logic from_above;
        if (j + 1 < NP) begin : g_b
            assign from_below = to_up[j+1];
        end else begin : g_nb
            assign from_below = 1'b0;
        end
        if (j > 0) begin : g_a
            assign from_above = to_down[j-1];
        end else begin : g_na
            assign from_above = 1'b0;
        end
        assign en_o[j] = to_self[j] | from_below | from_above;
    end

endmodule

// File: rtl/sss_steer_chk.sv
module sss_steer_chk
    import spare_shift_pkg::*;
#(
    parameter int Q      = 8,
    parameter bit SINGLE = 1'b0
) (
    input logic [Q-1:0]                  sel_i,
    input logic [field_w(Q, SINGLE)-1:0] fld_top_i,
    input logic [field_w(Q, SINGLE)-1:0] fld_bot_i,
    input logic [phys_n(Q, SINGLE)-1:0]  en_o
);

    localparam int NP = phys_n(Q, SINGLE);

    always_comb begin
        // R7
        count_match_chk: assert ($countones(en_o) == $countones(sel_i));
        // R6
        low_spare_gate_chk: assert (!en_o[NP-1] || (fld_bot_i != '0));
        if (!SINGLE) begin
            // R6
            top_spare_gate_chk: assert (!en_o[0] || ((fld_top_i != '0) && sel_i[0]));
            // R2
            if ((fld_top_i != '0) && (int'(fld_top_i) < NP))
                top_fault_idle_chk: assert (!en_o[int'(fld_top_i)]);
            // R3
            if ((fld_bot_i != '0) && (fld_bot_i >= fld_top_i) && (int'(fld_bot_i) + 1 < NP))
                bot_fault_idle_chk: assert (!en_o[int'(fld_bot_i) + 1]);
        end else begin
            // R8
            if ((fld_bot_i != '0) && (int'(fld_bot_i) - 1 < NP))
                single_fault_idle_chk: assert (!en_o[int'(fld_bot_i) - 1]);
        end
    end

endmodule

bind spare_shift_steer sss_steer_chk #(.Q(Q), .SINGLE(SINGLE)) chk_i (
    .sel_i     (sel_i),
    .fld_top_i (fld_top_i),
    .fld_bot_i (fld_bot_i),
    .en_o      (en_o)
);

// File: tb/spare_shift_steer_tb_top.sv
`timescale 1ns/1ps
module spare_shift_steer_tb_top;

    localparam int Q   = 8;
    localparam int FW  = 3;
    localparam int NP  = 10;
    localparam int FWS = 4;
    localparam int NPS = 9;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [Q-1:0]   sel;
    logic [FW-1:0]  fa;
    logic [FW-1:0]  fb;
    logic [NP-1:0]  en;
    logic [Q-1:0]   sel_s;
    logic [FWS-1:0] fa_s;
    logic [FWS-1:0] fb_s;
    logic [NPS-1:0] en_s;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    spare_shift_steer #(.Q(Q), .SINGLE(1'b0)) dut_i (
        .sel_i(sel), .fld_top_i(fa), .fld_bot_i(fb), .en_o(en)
    );

    spare_shift_steer #(.Q(Q), .SINGLE(1'b1)) dut_single_i (
        .sel_i(sel_s), .fld_top_i(fa_s), .fld_bot_i(fb_s), .en_o(en_s)
    );

    function automatic logic [NP-1:0] exp_unit(input logic [Q-1:0] s, input int a, input int b);
        logic [NP-1:0] r = '0;
        for (int i = 0; i < Q; i++) begin
            if (s[i]) begin
                int p = i + 1;
                if (a != 0 && p <= a)      p = p - 1;
                else if (b != 0 && p >= b + 1) p = p + 1;
                r[p] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [NPS-1:0] exp_single(input logic [Q-1:0] s, input int b);
        logic [NPS-1:0] r = '0;
        for (int i = 0; i < Q; i++) begin
            if (s[i]) begin
                int p = i;
                if (b != 0 && p >= b - 1) p = p + 1;
                r[p] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive_unit(input logic [Q-1:0] s, input int a, input int b);
        @(posedge clk);
        sel = s; fa = FW'(a); fb = FW'(b);
        @(negedge clk);
    endtask

    task automatic drive_single(input logic [Q-1:0] s, input int a, input int b);
        @(posedge clk);
        sel_s = s; fa_s = FWS'(a); fb_s = FWS'(b);
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        drive_unit('0, 0, 0);
        check("R7 idle unit", 16'(en), 16'd0);
        drive_single('0, 0, 0);
        check("R7 idle single", 16'(en_s), 16'd0);
    endtask

    task automatic t_fault_free;
        for (int i = 0; i < Q; i++) begin
            drive_unit(Q'(1) << i, 0, 0);
            check("R1 fault-free", 16'(en), 16'(1) << (i + 1));
        end
    endtask

    task automatic t_top_path;
        drive_unit(Q'(1), 1, 0);
        check("R2 a=1 sel0", 16'(en), 16'h0001);
        drive_unit(Q'(1) << 1, 1, 0);
        check("R2 a=1 sel1 stays", 16'(en), 16'h0004);
        for (int i = 0; i < Q; i++) begin
            drive_unit(Q'(1) << i, 3, 0);
            check("R2 a=3 sweep", 16'(en), 16'(exp_unit(Q'(1) << i, 3, 0)));
            check("R2 a=3 pos3 idle", 16'(en[3]), 16'd0);
        end
    endtask

    task automatic t_bottom_path;
        drive_unit(Q'(1) << 2, 0, 2);
        check("R3 b=2 sel2", 16'(en), 16'h0010);
        drive_unit(Q'(1) << 7, 0, 2);
        check("R3 b=2 sel7", 16'(en), 16'h0200);
        drive_unit(Q'(1) << 1, 0, 2);
        check("R3 b=2 sel1 stays", 16'(en), 16'h0004);
    endtask

    task automatic t_two_faults;
        for (int i = 0; i < Q; i++) begin
            drive_unit(Q'(1) << i, 1, 2);
            check("R4 faults 1,3", 16'(en), 16'(exp_unit(Q'(1) << i, 1, 2)));
            check("R4 pos1,3 idle", 16'({en[3], en[1]}), 16'd0);
        end
    endtask

    task automatic t_overlap;
        drive_unit(Q'(1) << 3, 5, 2);
        check("R5 up wins", 16'(en), 16'h0008);
        drive_unit(Q'(1) << 6, 5, 2);
        check("R5 beyond up run", 16'(en), 16'h0100);
    endtask

    task automatic t_spares;
        drive_unit(Q'(1) << 1, 4, 0);
        check("R6 upper spare needs sel0", 16'(en[0]), 16'd0);
        drive_unit(Q'(1) << 7, 4, 0);
        check("R6 lower spare needs b", 16'(en[NP-1]), 16'd0);
        drive_unit(Q'(1), 0, 5);
        check("R6 upper spare needs a", 16'(en[0]), 16'd0);
    endtask

    task automatic t_multi_hot;
        drive_unit('1, 2, 5);
        check("R7 all-hot", 16'(en), 16'(exp_unit('1, 2, 5)));
        drive_unit(8'b1010_0101, 6, 1);
        check("R7 overlap multi", 16'(en), 16'(exp_unit(8'b1010_0101, 6, 1)));
    endtask

    task automatic t_exhaustive;
        for (int a = 0; a < (1 << FW); a++)
            for (int b = 0; b < (1 << FW); b++)
                for (int i = 0; i < Q; i++) begin
                    drive_unit(Q'(1) << i, a, b);
                    check("R2 R3 R5 sweep", 16'(en), 16'(exp_unit(Q'(1) << i, a, b)));
                end
    endtask

    task automatic t_single;
        for (int b = 0; b < (1 << FWS); b++)
            for (int i = 0; i < Q; i++) begin
                drive_single(Q'(1) << i, (b * 5) % 16, b);
                check("R8 single", 16'(en_s), 16'(exp_single(Q'(1) << i, b)));
            end
        drive_single(Q'(1) << 7, 3, 0);
        check("R8 top field ignored", 16'(en_s), 16'h0080);
        drive_single(Q'(1) << 7, 0, 3);
        check("R8 b=3 spare", 16'(en_s), 16'h0100);
    endtask

    task automatic t_no_clock;
        @(negedge clk);
        sel = Q'(1) << 4; fa = 3'd0; fb = 3'd0;
        #0.5;
        check("R9 no clock a", 16'(en), 16'h0020);
        fb = 3'd4;
        #0.5;
        check("R9 no clock b", 16'(en), 16'h0040);
    endtask

    initial begin
        sel = '0; fa = '0; fb = '0;
        sel_s = '0; fa_s = '0; fb_s = '0;
        repeat (2) @(posedge clk);
        t_reset_state();
        t_fault_free();
        t_top_path();
        t_bottom_path();
        t_two_faults();
        t_overlap();
        t_spares();
        t_multi_hot();
        t_exhaustive();
        t_single();
        t_no_clock();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule